// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog of a small processor core. The system clock is divided down to the instruction rate. A counter running at that rate raises a chip-reset request when it reaches a selectable power-of-two span. Software restarts the count with clear strobes that the core decodes from its instructions. A halt strobe from the core also restarts the count, and so does the block's reset. On expiry the block emits a one-cycle reset request and sets a sticky timeout flag. The flag holds until the core clears it.

Three configuration inputs are captured once, on the first clock edge after reset is released: enable, span select and clear mode. Changes to them take effect only after the next reset. In single mode one dedicated clear strobe restarts the count. In paired mode two different strobes, "first" and "second", must both arrive, in either order, before the count restarts. One half of the pair, or the same half repeated, leaves the count running. Paired mode therefore guards against code that loops over a single clear instruction.

The top state machine has three states. ST_LOAD is entered on reset and captures the configuration. It goes to ST_RUN when enabled and to ST_OFF when disabled. ST_RUN and ST_OFF both hold until reset. The pairing machine also has three states: PAIR_NONE, PAIR_FIRST and PAIR_SECOND. From PAIR_NONE a first strobe goes to PAIR_FIRST and a second strobe goes to PAIR_SECOND. Both strobes in the same cycle restart the count and stay in PAIR_NONE. Receiving the missing half in PAIR_FIRST or PAIR_SECOND restarts the count and returns to PAIR_NONE. Repeating the half already held causes no transition.

Top module: `wdt_paired_clear`

## Requirements
- R1: While reset is low, and on the first edge after it rises, both outputs are 0. That first edge loads the configuration and is counting reference 0.
- R2: With no restart, the first reset request appears on the edge 4 * 2^(8+sel) clock cycles after the reference edge, for span select sel = 0..3.
- R3: In single mode (cfg_paired=0 at load), clr_single sampled at edge K makes the next request fall on edge K + 4 * 2^(8+sel).
- R4: In single mode, clr_first and clr_second have no effect on request timing.
- R5: In paired mode (cfg_paired=1 at load), the count restarts on the edge where both clr_first and clr_second have been seen, in either order, across cycles or in the same cycle. clr_single has no effect.
- R6: In paired mode, a single half, even when repeated, does not restart the count. Both pending halves are dropped when a pair completes, so a later lone half does not complete a new pair.
- R7: halt sampled at edge K restarts the count in either mode, so the next request is at K + 4 * 2^(8+sel).
- R8: When cfg_enable=0 at load, no request is ever raised and the flag stays 0 for any inputs.
- R9: wdt_rst_req is high for exactly one cycle. Counting restarts from the expiry edge, so the next request follows one full span later.
- R10: wdt_to_flag rises with the request and holds until stat_clr is sampled. A request and stat_clr in the same cycle leave the flag at 1.
- R11: A restart (clear or halt) sampled on the expiry edge wins: no request is raised, and the next request is one full span after that edge.
- R12: Changes to cfg_enable, cfg_sel and cfg_paired after the load edge have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Watchdog enable, captured at load |
| cfg_sel | input | 2 | Span select, span = 2^(8+cfg_sel) instruction ticks |
| cfg_paired | input | 1 | 1 = paired clear mode, 0 = single, captured at load |
| clr_single | input | 1 | Single-mode clear strobe |
| clr_first | input | 1 | Paired-mode first clear strobe |
| clr_second | input | 1 | Paired-mode second clear strobe |
| halt | input | 1 | Halt entry strobe, restarts the count |
| stat_clr | input | 1 | Clears the timeout flag |
| wdt_rst_req | output | 1 | One-cycle chip-reset request on expiry |
| wdt_to_flag | output | 1 | Sticky timeout flag |

## Verification
A restart and an expiry can fall in the same cycle, and so can a flag clear and a newly raised flag. The bench counts edges from a known reference and places clr_single exactly on the computed expiry edge. It expects no request there and the next request exactly one span later. It then places stat_clr on an expiry edge and expects the flag to stay set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_OFF  = 2'd2
    } wdt_state_e;

    typedef enum logic [1:0] {
        PAIR_NONE   = 2'd0,
        PAIR_FIRST  = 2'd1,
        PAIR_SECOND = 2'd2
    } pair_state_e;
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] psc_q;

    assign tick = run && (psc_q == PW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (clr) begin
            psc_q <= '0;
        end else if (run) begin
            psc_q <= tick ? '0 : psc_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_span_counter.sv
module wdt_span_counter #(
    parameter int N_MIN = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int SEL_N = 1 << SEL_W;
    localparam int CW    = N_MIN + SEL_N - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_tab [SEL_N];

    for (genvar g = 0; g < SEL_N; g++) begin : g_lim
        assign lim_tab[g] = CW'((64'd1 << (N_MIN + g)) - 64'd1);
    end

    assign expire = tick && (cnt_q == lim_tab[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_pair_fsm.sv
module wdt_pair_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic paired,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    output logic kick
);
    pair_state_e ps_q, ps_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= PAIR_NONE;
        else        ps_q <= ps_d;
    end

    always_comb begin
        ps_d = ps_q;
        kick = 1'b0;
        if (active) begin
            if (!paired) begin
                kick = clr_single;
            end else begin
                unique case (ps_q)
                    PAIR_NONE: begin
                        if (clr_first && clr_second) kick = 1'b1;
                        else if (clr_first)          ps_d = PAIR_FIRST;
                        else if (clr_second)         ps_d = PAIR_SECOND;
                    end
                    PAIR_FIRST: begin
                        if (clr_second) begin
                            kick = 1'b1;
                            ps_d = PAIR_NONE;
                        end
                    end
                    PAIR_SECOND: begin
                        if (clr_first) begin
                            kick = 1'b1;
                            ps_d = PAIR_NONE;
                        end
                    end
                    default: ps_d = PAIR_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/wdt_paired_clear.sv
module wdt_paired_clear
    import wdt_pkg::*;
#(
    parameter int DIV   = 4,
    parameter int N_MIN = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_paired,
    input  logic             clr_single,
    input  logic             clr_first,
    input  logic             clr_second,
    input  logic             halt,
    input  logic             stat_clr,
    output logic             wdt_rst_req,
    output logic             wdt_to_flag
);
    wdt_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             paired_q;
    logic             running, is_off, kick, restart, tick, expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = cfg_enable ? ST_RUN : ST_OFF;
            ST_RUN:  state_d = ST_RUN;
            ST_OFF:  state_d = ST_OFF;
            default: state_d = ST_LOAD;
        endcase
    end

    // configuration capture on the load edge only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            paired_q <= 1'b0;
        end else if (state_q == ST_LOAD) begin
            sel_q    <= cfg_sel;
            paired_q <= cfg_paired;
        end
    end

    assign running = (state_q == ST_RUN);
    assign is_off  = (state_q == ST_OFF);
    assign restart = running && (kick || halt);

    wdt_pair_fsm u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (running),
        .paired     (paired_q),
        .clr_single (clr_single),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .kick       (kick)
    );

    wdt_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .clr   (restart),
        .tick  (tick)
    );

    wdt_span_counter #(.N_MIN(N_MIN), .SEL_W(SEL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (restart),
        .sel    (sel_q),
        .expire (expire)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_rst_req <= 1'b0;
            wdt_to_flag <= 1'b0;
        end else begin
            wdt_rst_req <= expire && !restart;
            if (expire && !restart) wdt_to_flag <= 1'b1;
            else if (stat_clr)      wdt_to_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_paired_clear_chk.sv
module wdt_paired_clear_chk (
    input logic clk,
    input logic rst_n,
    input logic pulse,
    input logic flag,
    input logic stat_clr,
    input logic restart,
    input logic off
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse); // R9
    AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> flag); // R10
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (flag && !stat_clr) |=> flag); // R10
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) stat_clr |=> (!flag || pulse)); // R10
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n) restart |=> !pulse); // R11
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) off |-> (!pulse && !flag)); // R8
endmodule

bind wdt_paired_clear wdt_paired_clear_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse    (wdt_rst_req),
    .flag     (wdt_to_flag),
    .stat_clr (stat_clr),
    .restart  (restart),
    .off      (is_off)
);

// File: tb/tb_wdt_paired_clear.sv
`timescale 1ns/1ps
module tb_wdt_paired_clear;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b1;
    logic [1:0] cfg_sel = 2'd0;
    logic       cfg_paired = 1'b0;
    logic       clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
    logic       halt = 1'b0, stat_clr = 1'b0;
    logic       wdt_rst_req, wdt_to_flag;

    int tests = 0, fails = 0;
    int cyc = 0, npulse = 0, nexp = 0, last_edge = -1, dbl = 0;
    logic prev_p = 1'b0;

    always #2.5 clk = ~clk;

    wdt_paired_clear dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sel(cfg_sel),
        .cfg_paired(cfg_paired), .clr_single(clr_single), .clr_first(clr_first),
        .clr_second(clr_second), .halt(halt), .stat_clr(stat_clr),
        .wdt_rst_req(wdt_rst_req), .wdt_to_flag(wdt_to_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && wdt_rst_req) begin
            npulse    = npulse + 1;
            last_edge = cyc;
            if (prev_p) dbl = dbl + 1;
        end
        prev_p = rst_n && wdt_rst_req;
    end

    function automatic int span(input int sel);
        return 4 * (1 << (8 + sel));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) step();
    endtask

    // drive strobes sampled at the next edge; e returns that edge number
    task automatic drive(input logic s, input logic f, input logic sc,
                         input logic h, input logic sclr, output int e);
        clr_single = s; clr_first = f; clr_second = sc; halt = h; stat_clr = sclr;
        step();
        e = cyc;
        clr_single = 0; clr_first = 0; clr_second = 0; halt = 0; stat_clr = 0;
    endtask

    task automatic expect_pulse(input string tag, input int exp_e);
        while (npulse == nexp && cyc < exp_e + 4) step();
        nexp++;
        chk(tag, (npulse >= nexp) ? last_edge : -1, exp_e);
        chk({tag, " count"}, npulse, nexp);
        nexp = npulse;
    endtask

    task automatic do_reset(input logic en, input int sel, input logic pr, output int l);
        rst_n = 0; cfg_enable = en; cfg_sel = 2'(sel); cfg_paired = pr;
        repeat (3) step();
        chk("R1 rst req", int'(wdt_rst_req), 0);
        chk("R1 rst flag", int'(wdt_to_flag), 0);
        rst_n = 1;
        step();
        l = cyc;
        chk("R1 load req", int'(wdt_rst_req), 0);
        chk("R1 load flag", int'(wdt_to_flag), 0);
    endtask

    task automatic run_all();
        int l, e, e2, p;
        // R2 / R9: span per select, both modes, free running
        for (int pm = 0; pm < 2; pm++) begin
            for (int s = 0; s < 4; s++) begin
                do_reset(1'b1, s, pm[0], l);
                expect_pulse("R2 first expiry", l + span(s));
                step();
                chk("R9 pulse one cycle", int'(wdt_rst_req), 0);
                chk("R10 flag set", int'(wdt_to_flag), 1);
                expect_pulse("R9 periodic expiry", l + 2 * span(s));
            end
        end
        p = span(0);
        // R3, R4, R12: single mode
        do_reset(1'b1, 0, 1'b0, l);
        wait_to(l + 500);
        drive(1, 0, 0, 0, 0, e);
        wait_to(e + 100);  drive(0, 1, 0, 0, 0, e2);
        wait_to(e + 300);  drive(0, 0, 1, 0, 0, e2);
        wait_to(e + 400);  drive(0, 1, 1, 0, 0, e2);
        expect_pulse("R3 R4 single clear", e + p);
        cfg_paired = 1; cfg_enable = 0; cfg_sel = 2'd3;
        wait_to(e + p + 200);
        drive(1, 0, 0, 0, 0, e);
        expect_pulse("R12 config frozen", e + p);
        cfg_paired = 0; cfg_enable = 1; cfg_sel = 2'd0;
        // R5, R6: paired mode
        do_reset(1'b1, 0, 1'b1, l);
        wait_to(l + 100); drive(0, 1, 0, 0, 0, e);
        wait_to(l + 200); drive(0, 1, 0, 0, 0, e);
        expect_pulse("R6 lone half", l + p);
        wait_to(l + p + 50);  drive(0, 1, 0, 0, 0, e);
        wait_to(l + p + 100); drive(0, 0, 1, 0, 0, e);
        wait_to(e + 100); drive(0, 0, 1, 0, 0, e2);
        wait_to(e + 200); drive(0, 1, 0, 0, 0, e);
        wait_to(e + 100); drive(1, 0, 0, 0, 0, e2);
        wait_to(e + 200); drive(0, 0, 1, 0, 0, e2);
        expect_pulse("R5 R6 pair reversed then single ignored", e + p);
        wait_to(e + p + 50); drive(0, 1, 1, 0, 0, e);
        expect_pulse("R5 pair same cycle", e + p);
        // R7: halt in paired and single mode
        wait_to(e + p + 300); drive(0, 0, 0, 1, 0, e);
        expect_pulse("R7 halt paired", e + p);
        do_reset(1'b1, 1, 1'b0, l);
        wait_to(l + 700); drive(0, 0, 0, 1, 0, e);
        expect_pulse("R7 halt single", e + span(1));
        // R10, R11: coincident events
        do_reset(1'b1, 0, 1'b0, l);
        wait_to(l + p - 1); drive(0, 0, 0, 0, 1, e);
        expect_pulse("R10 set on expiry edge", l + p);
        chk("R10 set wins over clear", int'(wdt_to_flag), 1);
        wait_to(l + p + 40);
        chk("R10 flag holds", int'(wdt_to_flag), 1);
        drive(0, 0, 0, 0, 1, e);
        chk("R10 flag cleared", int'(wdt_to_flag), 0);
        wait_to(l + 2 * p - 1); drive(1, 0, 0, 0, 0, e);
        step();
        chk("R11 no pulse on restart edge", npulse, nexp);
        expect_pulse("R11 restart wins", l + 3 * p);
        // R8: disabled
        do_reset(1'b0, 0, 1'b0, l);
        for (int i = 0; i < 12; i++) begin
            wait_to(l + i * 200);
            drive(1, i[0], i[1], i[2], 0, e);
        end
        wait_to(l + 3 * p);
        chk("R8 disabled no request", npulse, nexp);
        chk("R8 disabled flag", int'(wdt_to_flag), 0);
        chk("R9 no back-to-back pulse", dbl, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule